// File: doc/BRIEF.md
# Second-Operand Barrel Shifter with Carry

This block prepares the second ALU operand of a 32-bit datapath. It takes a register value and applies one of five shift kinds to it: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry flag. The shift amount comes either from a 5-bit field in the instruction or from the low byte of a second register. The block also builds immediate operands, where an 8-bit constant is rotated right by twice a 4-bit rotate field. Every form also produces a shifter carry-out. That carry-out is the last bit shifted out, or the incoming carry when nothing moves.

The operand and carry are computed combinationally and registered once, so results appear one clock after the inputs. The source register value is only read. The block has no storage of its own beyond the output register.

Top module: `barrel_operand_shifter`

## Requirements
- R1: While `rst_n` is low, `operand_out` and `carry_out` read zero.
- R2: A result appears on the outputs on the first rising clock edge after its inputs are applied, and not before.
- R3: Kind code 0 (logical left) by n in 1..32 gives `src_val << n`, with carry-out equal to `src_val[32-n]`.
- R4: Kind code 1 (logical right) by n in 1..32 gives `src_val >> n`, with carry-out equal to `src_val[n-1]`.
- R5: Kind code 2 (arithmetic right) by n in 1..31 replicates bit 31 into the vacated bits, with carry-out `src_val[n-1]`; 0xA0000030 shifted by 2 gives 0xE800000C.
- R6: Kind code 3 (rotate right) by a non-zero n rotates by n modulo 32, and carry-out equals bit 31 of the result; a non-zero multiple of 32 returns the value with carry-out equal to its bit 31.
- R7: Kind code 4 (rotate through carry) ignores the amount: the result is `{carry_in, src_val[31:1]}` and carry-out is `src_val[0]`.
- R8: For kind codes 0 to 3, an amount of zero returns `src_val` unchanged and carry-out equals `carry_in`.
- R9: With `amt_from_reg` high the amount is `amt_reg[7:0]`, and bits 31:8 of `amt_reg` have no effect; with it low the amount is `amt_field`.
- R10: With `imm_mode` high the result is `imm_byte` zero-extended and rotated right by 2×`imm_rot`. Carry-out is `carry_in` when `imm_rot` is 0, and otherwise bit 31 of the result.
- R11: Kind codes 5, 6 and 7 return `src_val` unchanged with carry-out equal to `carry_in`.
- R12: Amounts above 32 give zero with carry-out 0 for both logical shifts. Amounts of 32 or more for arithmetic right give every bit, and the carry-out, equal to `src_val[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imm_mode | input | 1 | 1 selects the rotated-immediate form |
| imm_byte | input | 8 | Immediate constant |
| imm_rot | input | 4 | Immediate rotate field (rotation is twice this) |
| src_val | input | 32 | Register value to shift |
| shift_kind | input | 3 | 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 rotate through carry |
| amt_from_reg | input | 1 | 1 takes the amount from `amt_reg`, 0 from `amt_field` |
| amt_field | input | 5 | Instruction shift amount |
| amt_reg | input | 32 | Register holding the shift amount in its low byte |
| carry_in | input | 1 | Incoming carry flag |
| operand_out | output | 32 | Shifted operand, registered |
| carry_out | output | 1 | Shifter carry-out, registered |

## Verification
The bench builds the block with its default 32-bit width, 8-bit amount byte and 4-bit rotate field. At that size every register amount from 0 to 255 can be swept for all eight kind codes over several data patterns. This reaches the zero, exactly-32, above-32 and modulo-32 corners directly. All 32 instruction-field amounts and all 4096 immediate/rotate pairs under both carry values are swept as well. Expected values come from a bit-serial model that moves one bit per step.

// File: rtl/bsh_pkg.sv
`timescale 1ns/1ps
package bsh_pkg;

    typedef enum logic [2:0] {
        KIND_LSL = 3'd0,
        KIND_LSR = 3'd1,
        KIND_ASR = 3'd2,
        KIND_ROR = 3'd3,
        KIND_RRX = 3'd4
    } shift_kind_e;

endpackage

// File: rtl/bsh_amount.sv
`timescale 1ns/1ps
// Picks the effective shift amount: the instruction field, or the low
// byte of a register.
module bsh_amount #(
    parameter int DATA_W  = 32,
    parameter int AMT_W   = 8,
    parameter int FIELD_W = 5
) (
    input  logic               from_reg,
    input  logic [FIELD_W-1:0] field,
    input  logic [DATA_W-1:0]  reg_val,
    output logic [AMT_W-1:0]   amount,
    output logic               is_zero
);
    logic unused_high;

    always_comb begin
        unused_high = ^reg_val[DATA_W-1:AMT_W];
        if (from_reg) begin
            amount = reg_val[AMT_W-1:0];
        end else begin
            amount = AMT_W'(field);
        end
        is_zero = (amount == '0);
    end
endmodule

// File: rtl/bsh_reg_shift.sv
`timescale 1ns/1ps
// Register-operand shifter: five kinds, with carry-out.
module bsh_reg_shift
    import bsh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] val,
    input  logic [2:0]        kind,
    input  logic [AMT_W-1:0]  amount,
    input  logic              amt_zero,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int ROT_BITS = $clog2(DATA_W);

    logic [DATA_W:0]          lsl_ext;
    logic [DATA_W:0]          lsr_ext;
    logic signed [DATA_W:0]   asr_ext;
    logic [2*DATA_W-1:0]      ror_dbl;
    logic [ROT_BITS-1:0]      ror_amt;
    shift_kind_e              kind_e;

    always_comb begin
        kind_e  = shift_kind_e'(kind);
        // Extra bit beside the data catches the last bit shifted out.
        lsl_ext = {1'b0, val} << amount;
        lsr_ext = {val, 1'b0} >> amount;
        asr_ext = $signed({val, 1'b0}) >>> amount;
        ror_amt = amount[ROT_BITS-1:0];
        ror_dbl = {val, val} >> ror_amt;

        res  = val;
        cout = cin;
        unique case (kind_e)
            KIND_LSL: begin
                if (!amt_zero) begin
                    res  = lsl_ext[DATA_W-1:0];
                    cout = lsl_ext[DATA_W];
                end
            end
            KIND_LSR: begin
                if (!amt_zero) begin
                    res  = lsr_ext[DATA_W:1];
                    cout = lsr_ext[0];
                end
            end
            KIND_ASR: begin
                if (!amt_zero) begin
                    res  = asr_ext[DATA_W:1];
                    cout = asr_ext[0];
                end
            end
            KIND_ROR: begin
                if (!amt_zero) begin
                    res  = ror_dbl[DATA_W-1:0];
                    cout = ror_dbl[DATA_W-1];
                end
            end
            KIND_RRX: begin
                res  = {cin, val[DATA_W-1:1]};
                cout = val[0];
            end
            default: begin
                res  = val;
                cout = cin;
            end
        endcase
    end
endmodule

// File: rtl/bsh_imm_rot.sv
`timescale 1ns/1ps
// Immediate operand: constant rotated right by twice the rotate field,
// built as one fixed-rotate stage per bit of the field.
module bsh_imm_rot #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic [ROT_W-1:0]  rot,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    logic [DATA_W-1:0] stage [ROT_W+1];

    assign stage[0] = DATA_W'(imm);

    generate
        for (genvar k = 0; k < ROT_W; k++) begin : g_stage
            localparam int STEP = 2 << k;
            always_comb begin
                if (rot[k]) begin
                    stage[k+1] = {stage[k][STEP-1:0], stage[k][DATA_W-1:STEP]};
                end else begin
                    stage[k+1] = stage[k];
                end
            end
        end
    endgenerate

    always_comb begin
        res  = stage[ROT_W];
        cout = (rot == '0) ? cin : stage[ROT_W][DATA_W-1];
    end
endmodule

// File: rtl/barrel_operand_shifter.sv
`timescale 1ns/1ps
module barrel_operand_shifter #(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 8,
    parameter int ROT_W   = 4,
    parameter int AMT_W   = 8,
    parameter int FIELD_W = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               imm_mode,
    input  logic [IMM_W-1:0]   imm_byte,
    input  logic [ROT_W-1:0]   imm_rot,
    input  logic [DATA_W-1:0]  src_val,
    input  logic [2:0]         shift_kind,
    input  logic               amt_from_reg,
    input  logic [FIELD_W-1:0] amt_field,
    input  logic [DATA_W-1:0]  amt_reg,
    input  logic               carry_in,
    output logic [DATA_W-1:0]  operand_out,
    output logic               carry_out
);
    typedef struct packed {
        logic [DATA_W-1:0] operand;
        logic              carry;
    } out_t;

    out_t nxt_d;
    out_t out_q;

    logic [AMT_W-1:0]  amount;
    logic              amt_zero;
    logic [DATA_W-1:0] reg_res;
    logic              reg_cout;
    logic [DATA_W-1:0] imm_res;
    logic              imm_cout;

    bsh_amount #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W),
        .FIELD_W(FIELD_W)
    ) u_amount (
        .from_reg(amt_from_reg),
        .field   (amt_field),
        .reg_val (amt_reg),
        .amount  (amount),
        .is_zero (amt_zero)
    );

    bsh_reg_shift #(
        .DATA_W(DATA_W),
        .AMT_W (AMT_W)
    ) u_reg_shift (
        .val     (src_val),
        .kind    (shift_kind),
        .amount  (amount),
        .amt_zero(amt_zero),
        .cin     (carry_in),
        .res     (reg_res),
        .cout    (reg_cout)
    );

    bsh_imm_rot #(
        .DATA_W(DATA_W),
        .IMM_W (IMM_W),
        .ROT_W (ROT_W)
    ) u_imm_rot (
        .imm (imm_byte),
        .rot (imm_rot),
        .cin (carry_in),
        .res (imm_res),
        .cout(imm_cout)
    );

    always_comb begin
        if (imm_mode) begin
            nxt_d.operand = imm_res;
            nxt_d.carry   = imm_cout;
        end else begin
            nxt_d.operand = reg_res;
            nxt_d.carry   = reg_cout;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= nxt_d;
        end
    end

    assign operand_out = out_q.operand;
    assign carry_out   = out_q.carry;
endmodule

// File: rtl/bsh_checker.sv
`timescale 1ns/1ps
module bsh_checker #(
    parameter int DATA_W  = 32,
    parameter int ROT_W   = 4,
    parameter int AMT_W   = 8,
    parameter int FIELD_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               imm_mode,
    input logic [ROT_W-1:0]   imm_rot,
    input logic [DATA_W-1:0]  src_val,
    input logic [2:0]         shift_kind,
    input logic               amt_from_reg,
    input logic [FIELD_W-1:0] amt_field,
    input logic [DATA_W-1:0]  amt_reg,
    input logic               carry_in,
    input logic [DATA_W-1:0]  operand_out,
    input logic               carry_out
);
    logic             armed_q;
    logic [AMT_W-1:0] eff_amt;
    logic             unused_amt_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    always_comb begin
        unused_amt_hi = ^amt_reg[DATA_W-1:AMT_W];
        eff_amt = amt_from_reg ? amt_reg[AMT_W-1:0] : AMT_W'(amt_field);
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (!rst_n || (operand_out == '0 && !carry_out))); // R1

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(!imm_mode && shift_kind <= 3'd3 && eff_amt == '0))
        |-> (operand_out == $past(src_val) && carry_out == $past(carry_in))); // R8

    AST_LSL_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(!imm_mode && shift_kind == 3'd0 && eff_amt > AMT_W'(DATA_W)))
        |-> (operand_out == '0 && !carry_out)); // R12

    AST_ASR_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(!imm_mode && shift_kind == 3'd2 && eff_amt >= AMT_W'(DATA_W)))
        |-> (operand_out == {DATA_W{$past(src_val[DATA_W-1])}}
             && carry_out == $past(src_val[DATA_W-1]))); // R12

    AST_ROR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(!imm_mode && shift_kind == 3'd3 && eff_amt != '0))
        |-> (carry_out == operand_out[DATA_W-1])); // R6

    AST_RRX_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(!imm_mode && shift_kind == 3'd4))
        |-> (carry_out == $past(src_val[0])
             && operand_out[DATA_W-1] == $past(carry_in))); // R7

    AST_IMM_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(imm_mode))
        |-> (carry_out == ($past(imm_rot == '0) ? $past(carry_in)
                                                : operand_out[DATA_W-1]))); // R10

    AST_OTHER_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(!imm_mode && shift_kind >= 3'd5))
        |-> (operand_out == $past(src_val) && carry_out == $past(carry_in))); // R11
endmodule

bind barrel_operand_shifter bsh_checker #(
    .DATA_W (DATA_W),
    .ROT_W  (ROT_W),
    .AMT_W  (AMT_W),
    .FIELD_W(FIELD_W)
) u_bsh_checker (.*);

// File: tb/barrel_operand_shifter_bench.sv
`timescale 1ns/1ps
module barrel_operand_shifter_bench;
    localparam int DW = 32;

    logic          clk;
    logic          rst_n;
    logic          imm_mode;
    logic [7:0]    imm_byte;
    logic [3:0]    imm_rot;
    logic [DW-1:0] src_val;
    logic [2:0]    shift_kind;
    logic          amt_from_reg;
    logic [4:0]    amt_field;
    logic [DW-1:0] amt_reg;
    logic          carry_in;
    logic [DW-1:0] operand_out;
    logic          carry_out;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    barrel_operand_shifter u_barrel_operand_shifter (
        .clk(clk), .rst_n(rst_n), .imm_mode(imm_mode), .imm_byte(imm_byte),
        .imm_rot(imm_rot), .src_val(src_val), .shift_kind(shift_kind),
        .amt_from_reg(amt_from_reg), .amt_field(amt_field), .amt_reg(amt_reg),
        .carry_in(carry_in), .operand_out(operand_out), .carry_out(carry_out)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Bit-serial model: moves one bit per step, returns {carry, value}.
    function automatic logic [DW:0] model_reg(int kind, logic [DW-1:0] v, int n, logic c);
        logic [DW-1:0] x = v;
        logic          cy = c;
        case (kind)
            0: for (int i = 0; i < n; i++) begin cy = x[DW-1]; x = x << 1; end
            1: for (int i = 0; i < n; i++) begin cy = x[0]; x = x >> 1; end
            2: for (int i = 0; i < n; i++) begin cy = x[0]; x = {x[DW-1], x[DW-1:1]}; end
            3: for (int i = 0; i < n; i++) begin cy = x[0]; x = {x[0], x[DW-1:1]}; end
            4: begin cy = v[0]; x = {c, v[DW-1:1]}; end
            default: begin cy = c; x = v; end
        endcase
        return {cy, x};
    endfunction

    function automatic logic [DW:0] model_imm(logic [7:0] b, int rot, logic c);
        logic [DW-1:0] x = DW'(b);
        logic          cy = c;
        for (int i = 0; i < 2 * rot; i++) begin cy = x[0]; x = {x[0], x[DW-1:1]}; end
        return {cy, x};
    endfunction

    function automatic string tag_of(int kind, int n);
        if (kind >= 5) return "R11";
        if (kind == 4) return "R7";
        if (n == 0) return "R8";
        case (kind)
            0: return (n > 32) ? "R12" : "R3";
            1: return (n > 32) ? "R12" : "R4";
            2: return (n >= 32) ? "R12" : "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string req, logic [DW-1:0] exp_v, logic exp_c);
        checks++;
        if (operand_out !== exp_v || carry_out !== exp_c) begin
            failures++;
            $display("FAIL %s: actual %h carry %b, expected %h carry %b",
                     req, operand_out, carry_out, exp_v, exp_c);
        end
    endtask

    // Inputs change at a falling edge; the result is sampled one falling edge later.
    task automatic apply_reg(int kind, logic [DW-1:0] v, logic from_reg,
                             logic [4:0] fld, logic [DW-1:0] ra, logic c);
        imm_mode = 1'b0; shift_kind = 3'(kind); src_val = v;
        amt_from_reg = from_reg; amt_field = fld; amt_reg = ra; carry_in = c;
        @(negedge clk);
    endtask

    task automatic apply_imm(logic [7:0] b, logic [3:0] r, logic c);
        imm_mode = 1'b1; imm_byte = b; imm_rot = r; carry_in = c;
        src_val = 32'h5A5A_5A5A; shift_kind = 3'd1; amt_from_reg = 1'b0; amt_field = 5'd7;
        @(negedge clk);
    endtask

    logic [DW-1:0] pats [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA000_0030,
                                32'h8000_0001, 32'h1234_5678, 32'h7FFF_FFFE};

    initial begin
        logic [DW:0] e;
        rst_n = 1'b0; imm_mode = 1'b0; imm_byte = 8'hFF; imm_rot = 4'd3;
        src_val = 32'hDEAD_BEEF; shift_kind = 3'd0; amt_from_reg = 1'b0;
        amt_field = 5'd4; amt_reg = '0; carry_in = 1'b1;
        repeat (5) @(negedge clk);
        check("R1", '0, 1'b0);
        rst_n = 1'b1;

        // R2: latency of one edge
        apply_reg(0, 32'h0000_0001, 1'b0, 5'd4, '0, 1'b0);
        check("R2", 32'h0000_0010, 1'b0);
        imm_mode = 1'b0; shift_kind = 3'd1; src_val = 32'h8000_0000;
        amt_field = 5'd3; carry_in = 1'b0;
        #2;
        check("R2", 32'h0000_0010, 1'b0);
        @(negedge clk);
        check("R2", 32'h1000_0000, 1'b0);

        // R5 worked example
        apply_reg(2, 32'hA000_0030, 1'b0, 5'd2, '0, 1'b0);
        check("R5", 32'hE800_000C, 1'b0);

        // R3..R8, R11, R12: register amount sweep over all byte values
        for (int p = 0; p < 6; p++) begin
            for (int k = 0; k < 8; k++) begin
                for (int n = 0; n < 256; n++) begin
                    logic c = 1'((n + k + p) & 1);
                    apply_reg(k, pats[p], 1'b1, 5'd0, DW'(n), c);
                    e = model_reg(k, pats[p], n, c);
                    check(tag_of(k, n), e[DW-1:0], e[DW]);
                end
            end
        end

        // R9: instruction-field amounts, and register upper bits ignored
        for (int p = 0; p < 6; p++) begin
            for (int k = 0; k < 5; k++) begin
                for (int n = 0; n < 32; n++) begin
                    for (int c = 0; c < 2; c++) begin
                        apply_reg(k, pats[p], 1'b0, 5'(n), 32'hFFFF_FF00, 1'(c));
                        e = model_reg(k, pats[p], n, 1'(c));
                        check("R9", e[DW-1:0], e[DW]);
                    end
                end
            end
        end
        for (int k = 0; k < 4; k++) begin
            for (int n = 0; n < 40; n++) begin
                apply_reg(k, 32'hC3A5_0F96, 1'b1, 5'd17, {24'hABCDEF, 8'(n)}, 1'b1);
                e = model_reg(k, 32'hC3A5_0F96, n, 1'b1);
                check("R9", e[DW-1:0], e[DW]);
            end
        end

        // R10: every immediate byte with every rotate value
        for (int b = 0; b < 256; b++) begin
            for (int r = 0; r < 16; r++) begin
                for (int c = 0; c < 2; c++) begin
                    apply_imm(8'(b), 4'(r), 1'(c));
                    e = model_imm(8'(b), r, 1'(c));
                    check("R10", e[DW-1:0], e[DW]);
                end
            end
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule